// File: doc/BRIEF.md
# Debug exception status register

This block holds the status word that a processor debug unit keeps about its own exceptions. Each time a debug exception is taken, it records whether the exception was a breakpoint. It also records whether a non-maskable interrupt or some other ordinary exception arrived in the same cycle, so that the debug handler knows where to send execution when it returns. From the stored coincidence flags and the current boot-exception-vector select bit, it offers a suggested redirect address.

While debug mode is active, two sticky flags catch faults on data accesses: a translation-buffer fault flag and a bus-error flag. Software clears each flag by writing 0 to its bit. The register also holds the single-step enable. Its effective value is forced off while debug mode is active, so the debug handler itself is never single-stepped.

The event inputs are one-cycle strobes that arrive from the exception logic in the same cycle as the event. Software reads the register value continuously and writes it through a simple write-enable and data port.

Top module: `dbg_xstat_reg`

## Requirements
- R1: After reset, every bit of the status word is 0, the effective single-step enable is 0 and the redirect vector is 0.
- R2: When a debug entry strobe coincides with the non-maskable interrupt strobe, the NMI-coincidence flag (bit 2) becomes 1 and the other-exception flag (bit 3) becomes 0 on the next cycle, whatever the other-exception input is.
- R3: When a debug entry strobe arrives without the NMI strobe, bit 3 takes the value of the other-exception input and bit 2 becomes 0. The other-exception input covers every exception except reset, NMI and user-segment refill.
- R4: Bit 1 takes the breakpoint-cause input on each debug entry. Bits 1 to 3 hold their values in every cycle without a debug entry, and software writes do not change them.
- R5: The redirect vector is 0xBFC00000 while bit 2 is set. Otherwise, while bit 3 is set, it is 0xBFC00180 when the boot-vector select input is 1 and 0x80000080 when it is 0. With neither flag set it is 0.
- R6: The translation-buffer fault flag (bit 4) is set when a translation-buffer fault strobe occurs on a load or store (memory qualifier high) while debug mode is active. It is not set when debug mode is inactive or the qualifier is low.
- R7: The bus-error flag (bit 5) is set when a bus-error strobe occurs on a load or store while debug mode is active. It is not set when debug mode is inactive or the qualifier is low.
- R8: A software write with 0 in bit 4 or bit 5 clears that flag, and a write with 1 there leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R9: The single-step enable (bit 0) resets to 0 and takes bit 0 of every software write. The effective enable output equals bit 0 while debug mode is inactive and is 0 while debug mode is active.
- R10: Bits 31 to 6 of the status word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_active | input | 1 | Debug mode is active |
| dbg_entry | input | 1 | One-cycle strobe: a debug exception is taken |
| dbg_is_brk | input | 1 | The debug exception being taken is a breakpoint |
| ev_nmi | input | 1 | Non-maskable interrupt strobe |
| ev_other | input | 1 | Strobe for any exception other than reset, NMI or user-segment refill |
| ev_tlb | input | 1 | Translation-buffer fault strobe (refill, user refill or modify) |
| ev_bus | input | 1 | Bus-error strobe |
| ev_mem | input | 1 | The faulting instruction is a load or store |
| bev | input | 1 | Boot-exception-vector select bit |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 32 | Software write data |
| stat_q | output | 32 | Status word value |
| step_en_eff | output | 1 | Effective single-step enable |
| redirect_vec | output | 32 | Suggested redirect vector |

## Verification
The assertions assume that the event inputs are clean single-cycle strobes sampled only at clock edges. They do not assume that strobes are mutually exclusive: NMI, other-exception, fault and software-write strobes may all land in the same cycle. The assertions, and the priority rules they check, are written for that overlap. The stimulus drives every input at random on the falling edge, including simultaneous entry, NMI and clearing writes. Directed sequences add the hardware-set-against-clear race and writes of 1 to set flags.

// File: rtl/dbg_xstat_pkg.sv
// Package: shared widths, bit positions and vector constants for the
// debug exception status register. Assumes a 32-bit register word.
package dbg_xstat_pkg;
    localparam int XLEN     = 32;
    localparam int BIT_STEP = 0;
    localparam int BIT_BRK  = 1;
    localparam int BIT_NMI  = 2;
    localparam int BIT_OTH  = 3;
    localparam int BIT_FLT0 = 4;   // first of the contiguous sticky fault flags
    localparam int NFLT     = 2;   // fault flags: translation buffer, bus
    localparam int BIT_TOP  = BIT_FLT0 + NFLT; // first always-zero bit

    localparam logic [XLEN-1:0] VEC_NMI  = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] VEC_BOOT = 32'hBFC0_0180;
    localparam logic [XLEN-1:0] VEC_NORM = 32'h8000_0080;
endpackage

// File: rtl/dbg_xstat_cause.sv
// Module: captures the debug entry cause (breakpoint) and the ordinary
// exception that coincided with it. NMI outranks other exceptions.
// Assumes entry and event inputs are single-cycle strobes.
module dbg_xstat_cause (
    input  logic clk,
    input  logic rst_n,
    input  logic entry,
    input  logic is_brk,
    input  logic nmi,
    input  logic other,
    output logic brk_q,
    output logic nmi_q,
    output logic oth_q
);
    // Rewrite the cause flags on every debug entry, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_q <= 1'b0;
            nmi_q <= 1'b0;
            oth_q <= 1'b0;
        end else if (entry) begin
            brk_q <= is_brk;
            nmi_q <= nmi;
            oth_q <= other & ~nmi;
        end
    end
endmodule

// File: rtl/dbg_xstat_sticky.sv
// Module: one sticky flag, set by hardware, cleared by a software write
// of zero. Assumes set and clear are evaluated in the same cycle.
module dbg_xstat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // A hardware set takes priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/dbg_xstat_vec.sv
// Module: selects the suggested redirect vector from the stored
// coincidence flags and the boot-vector select. Purely combinational.
module dbg_xstat_vec
    import dbg_xstat_pkg::*;
(
    input  logic            nmi_q,
    input  logic            oth_q,
    input  logic            bev,
    output logic [XLEN-1:0] vec
);
    // NMI vector first, then the other-exception vector chosen by bev.
    always_comb begin
        if (nmi_q)      vec = VEC_NMI;
        else if (oth_q) vec = bev ? VEC_BOOT : VEC_NORM;
        else            vec = '0;
    end
endmodule

// File: rtl/dbg_xstat_reg.sv
// Module: top of the debug exception status register. It joins the cause
// capture, the sticky fault flags, the single-step enable and the vector
// select into one status word. It assumes that event inputs are
// single-cycle strobes and that software writes take effect on the next
// clock edge.
module dbg_xstat_reg
    import dbg_xstat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_active,
    input  logic            dbg_entry,
    input  logic            dbg_is_brk,
    input  logic            ev_nmi,
    input  logic            ev_other,
    input  logic            ev_tlb,
    input  logic            ev_bus,
    input  logic            ev_mem,
    input  logic            bev,
    input  logic            sw_we,
    input  logic [XLEN-1:0] sw_wdata,
    output logic [XLEN-1:0] stat_q,
    output logic            step_en_eff,
    output logic [XLEN-1:0] redirect_vec
);
    logic            brk_q, nmi_q, oth_q, step_q;
    logic [NFLT-1:0] flt_set, flt_clr, flt_q;

    dbg_xstat_cause u_cause (
        .clk    (clk),
        .rst_n  (rst_n),
        .entry  (dbg_entry),
        .is_brk (dbg_is_brk),
        .nmi    (ev_nmi),
        .other  (ev_other),
        .brk_q  (brk_q),
        .nmi_q  (nmi_q),
        .oth_q  (oth_q)
    );

    // Fault set conditions: only data accesses while in debug mode.
    always_comb begin
        flt_set[0] = dbg_active & ev_mem & ev_tlb;
        flt_set[1] = dbg_active & ev_mem & ev_bus;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NFLT; gi++) begin : g_flt
            assign flt_clr[gi] = sw_we & ~sw_wdata[BIT_FLT0 + gi];
            dbg_xstat_sticky u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (flt_set[gi]),
                .clr   (flt_clr[gi]),
                .q     (flt_q[gi])
            );
        end
    endgenerate

    // Single-step enable: plain read/write bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     step_q <= 1'b0;
        else if (sw_we) step_q <= sw_wdata[BIT_STEP];
    end

    // Effective step enable is suppressed inside debug mode.
    assign step_en_eff = step_q & ~dbg_active;

    dbg_xstat_vec u_vec (
        .nmi_q (nmi_q),
        .oth_q (oth_q),
        .bev   (bev),
        .vec   (redirect_vec)
    );

    // Assemble the status word; unassigned bits stay zero.
    always_comb begin
        stat_q                         = '0;
        stat_q[BIT_STEP]               = step_q;
        stat_q[BIT_BRK]                = brk_q;
        stat_q[BIT_NMI]                = nmi_q;
        stat_q[BIT_OTH]                = oth_q;
        stat_q[BIT_FLT0 +: NFLT]       = flt_q;
    end
endmodule

// File: rtl/dbg_xstat_chk.sv
// Module: property checker for the debug exception status register,
// attached to the top module by the bind statement at the end of this file.
// Assumes synchronous active-low reset.
module dbg_xstat_chk
    import dbg_xstat_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            dbg_active,
    input logic            dbg_entry,
    input logic            ev_nmi,
    input logic            ev_other,
    input logic            ev_tlb,
    input logic            ev_bus,
    input logic            ev_mem,
    input logic            bev,
    input logic            sw_we,
    input logic [XLEN-1:0] sw_wdata,
    input logic [XLEN-1:0] stat_q,
    input logic            step_en_eff,
    input logic [XLEN-1:0] redirect_vec
);
    a_r2_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_entry && ev_nmi |=> stat_q[BIT_NMI] && !stat_q[BIT_OTH]);

    a_r3_other_taken: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_entry && !ev_nmi |=> !stat_q[BIT_NMI] && (stat_q[BIT_OTH] == $past(ev_other)));

    a_r4_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_entry |=> $stable(stat_q[BIT_OTH:BIT_BRK]));

    a_r5_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[BIT_NMI] |-> redirect_vec == VEC_NMI);

    a_r5_other_vector: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[BIT_OTH] && !stat_q[BIT_NMI] |-> redirect_vec == (bev ? VEC_BOOT : VEC_NORM));

    a_r6_tlb_set: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active && ev_mem && ev_tlb |=> stat_q[BIT_FLT0]);

    a_r7_bus_set: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active && ev_mem && ev_bus |=> stat_q[BIT_FLT0 + 1]);

    a_r8_tlb_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_we && !sw_wdata[BIT_FLT0]) |=> stat_q[BIT_FLT0] >= $past(stat_q[BIT_FLT0]));

    a_r9_step_gated: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active |-> !step_en_eff);

    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[XLEN-1:BIT_TOP] == '0);
endmodule

bind dbg_xstat_reg dbg_xstat_chk u_chk (.*);

// File: tb/dbg_xstat_reg_test.sv
// Bench: a behavioural reference model stepped on every clock and compared
// field by field with the design; directed phases and then random stimulus.
module dbg_xstat_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_active = 0, dbg_entry = 0, dbg_is_brk = 0;
    logic        ev_nmi = 0, ev_other = 0, ev_tlb = 0, ev_bus = 0, ev_mem = 0;
    logic        bev = 0, sw_we = 0;
    logic [31:0] sw_wdata = 0;
    logic [31:0] stat_q, redirect_vec;
    logic        step_en_eff;

    int total = 0;
    int bad   = 0;

    // reference model state
    bit m_step, m_brk, m_nmi, m_oth, m_tlb, m_bus;

    dbg_xstat_reg uut (.*);

    always #2.5 clk = ~clk;   // 200 MHz

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_vec();
        if (m_nmi) return 32'hBFC0_0000;
        if (m_oth) return bev ? 32'hBFC0_0180 : 32'h8000_0080;
        return 32'h0;
    endfunction

    task automatic compare_all();
        check("R9 step bit",        {31'b0, stat_q[0]}, {31'b0, m_step});
        check("R9 effective step",  {31'b0, step_en_eff}, {31'b0, m_step && !dbg_active});
        check("R4 breakpoint bit",  {31'b0, stat_q[1]}, {31'b0, m_brk});
        check("R2 nmi flag",        {31'b0, stat_q[2]}, {31'b0, m_nmi});
        check("R3 other flag",      {31'b0, stat_q[3]}, {31'b0, m_oth});
        check("R6,R8 tlb flag",     {31'b0, stat_q[4]}, {31'b0, m_tlb});
        check("R7,R8 bus flag",     {31'b0, stat_q[5]}, {31'b0, m_bus});
        check("R10 upper bits",     {6'b0, stat_q[31:6]}, 32'h0);
        check("R5 redirect vector", redirect_vec, exp_vec());
    endtask

    // Model update for one rising edge from the inputs currently driven.
    task automatic model_edge();
        if (!rst_n) begin
            {m_step, m_brk, m_nmi, m_oth, m_tlb, m_bus} = '0;
        end else begin
            if (dbg_entry) begin
                m_brk = dbg_is_brk;
                m_nmi = ev_nmi;
                m_oth = ev_nmi ? 1'b0 : ev_other;
            end
            if (dbg_active && ev_mem && ev_tlb) m_tlb = 1;
            else if (sw_we && !sw_wdata[4])     m_tlb = 0;
            if (dbg_active && ev_mem && ev_bus) m_bus = 1;
            else if (sw_we && !sw_wdata[5])     m_bus = 0;
            if (sw_we) m_step = sw_wdata[0];
        end
    endtask

    // One cycle: the caller drives on the falling edge, then the model steps
    // at the rising edge and both are compared 1 ns later.
    task automatic cycle();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic idle();
        {dbg_entry, dbg_is_brk, ev_nmi, ev_other, ev_tlb, ev_bus, ev_mem, sw_we} = '0;
        sw_wdata = '0;
    endtask

    initial begin : watchdog
        #500000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        idle();
        cycle(); cycle();
        // R1 reset state
        check("R1 reset word", stat_q, 32'h0);
        check("R1 reset step", {31'b0, step_en_eff}, 32'h0);
        check("R1 reset vector", redirect_vec, 32'h0);
        rst_n = 1'b1;
        cycle();

        // R2: entry with NMI and other together; NMI wins
        dbg_entry = 1; ev_nmi = 1; ev_other = 1; dbg_is_brk = 1; cycle();
        idle(); cycle();
        check("R2 nmi-only word", stat_q & 32'hE, 32'h6);
        // R4: software write does not disturb cause bits
        sw_we = 1; sw_wdata = 32'h0; cycle(); idle(); cycle();
        check("R4 cause held after write", stat_q & 32'hE, 32'h6);
        // R3/R5: other exception only, both bev values
        dbg_entry = 1; ev_other = 1; cycle(); idle(); bev = 1; cycle();
        check("R5 vector bev=1", redirect_vec, 32'hBFC0_0180);
        bev = 0; cycle();
        check("R5 vector bev=0", redirect_vec, 32'h8000_0080);
        // R6/R7 outside debug mode: no set
        dbg_active = 0; ev_mem = 1; ev_tlb = 1; ev_bus = 1; cycle(); idle(); cycle();
        check("R6 R7 no set outside debug", stat_q & 32'h30, 32'h0);
        // R6: no set without memory qualifier
        dbg_active = 1; ev_tlb = 1; ev_bus = 1; cycle(); idle(); cycle();
        check("R6 R7 no set without qualifier", stat_q & 32'h30, 32'h0);
        // set both, then write ones: kept
        ev_mem = 1; ev_tlb = 1; ev_bus = 1; cycle(); idle();
        sw_we = 1; sw_wdata = 32'h30; cycle(); idle(); cycle();
        check("R8 write 1 keeps flags", stat_q & 32'h30, 32'h30);
        // R8: set against clear in the same cycle
        ev_mem = 1; ev_tlb = 1; sw_we = 1; sw_wdata = 32'h0; cycle(); idle(); cycle();
        check("R8 set beats clear", stat_q & 32'h30, 32'h10);
        sw_we = 1; sw_wdata = 32'h0; cycle(); idle(); cycle();
        check("R8 clear by zero", stat_q & 32'h30, 32'h0);
        // R9: step enable in and out of debug mode
        sw_we = 1; sw_wdata = 32'h1; cycle(); idle();
        dbg_active = 1; cycle();
        check("R9 gated in debug", {31'b0, step_en_eff}, 32'h0);
        dbg_active = 0; cycle();
        check("R9 enabled outside debug", {31'b0, step_en_eff}, 32'h1);

        // random phase, including an occasional reset
        for (int i = 0; i < 3000; i++) begin
            rst_n      = ($urandom_range(0, 199) != 0);
            dbg_active = $urandom_range(0, 1);
            dbg_entry  = ($urandom_range(0, 3) == 0);
            dbg_is_brk = $urandom_range(0, 1);
            ev_nmi     = ($urandom_range(0, 3) == 0);
            ev_other   = $urandom_range(0, 1);
            ev_tlb     = ($urandom_range(0, 5) == 0);
            ev_bus     = ($urandom_range(0, 5) == 0);
            ev_mem     = $urandom_range(0, 1);
            bev        = $urandom_range(0, 1);
            sw_we      = ($urandom_range(0, 4) == 0);
            sw_wdata   = $urandom;
            cycle();
        end
        idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule